// File: doc/BRIEF.md
# Pipeline Operand Bypass and Hazard Controller

This block is the control logic that sits beside a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the register specifiers and control bits held in the four pipeline registers. It decides where each of the two ALU operands of the instruction in execute comes from. The choices are the register file value, the result waiting in the execute/memory register, or the result waiting in the memory/writeback register.

The same block detects hazards that bypassing cannot hide, and it stalls decode and fetch for them. The first is a load immediately followed by an instruction that reads the loaded register. The second is a branch in decode whose comparison needs a value that is not yet in the register file. Branches are resolved in decode, so a taken branch discards the instruction being fetched behind it, but only once the branch itself is allowed to advance. The logic is purely combinational. Every output is a function of the current pipeline-register contents, and the pipeline registers themselves live in the datapath.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: `fwd_a` is 1 (take the execute/memory result) when `exmem_regwr` is high, `exmem_rd` is nonzero and `exmem_rd` equals `idex_rs`.
- R2: When R1 does not apply, `fwd_a` is 2 (take the memory/writeback result) when `memwb_regwr` is high, `memwb_rd` is nonzero and `memwb_rd` equals `idex_rs`; otherwise `fwd_a` is 0 (register file).
- R3: When both later stages match the same source register, the newer execute/memory result wins and the select is 1.
- R4: `fwd_b` follows the rules of R1 to R3 against `idex_rt` instead of `idex_rs`.
- R5: Register 0 never produces a bypass match: a destination of 0 leaves the select at 0 even with its write enable high. The value 3 never appears on a select.
- R6: A load-use hazard drives `pc_we` and `ifid_we` low and `idex_bubble` high. The hazard is `idex_memrd` high with a nonzero `idex_rt` equal to `ifid_rs` or `ifid_rt`.
- R7: A load whose target is register 0, or a non-load instruction in execute whose destination matches, causes no load-use stall.
- R8: A branch in decode (`ifid_is_branch`) stalls when the instruction in execute writes (`idex_regwr`) a nonzero `idex_rd` equal to `ifid_rs` or `ifid_rt`.
- R9: A branch in decode stalls when a load in memory (`exmem_memrd`) targets a nonzero `exmem_rd` equal to `ifid_rs` or `ifid_rt`.
- R10: A taken branch in decode (`ifid_is_branch` and `branch_taken`) that is not stalled drives `if_flush` high.
- R11: A stall takes priority over the flush: while any stall is active, `if_flush` is low.
- R12: With no hazard, `pc_we` and `ifid_we` are 1, `idex_bubble` is 0, and `if_flush` is 0 unless R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | REG_AW | First source register of the instruction in decode |
| ifid_rt | input | REG_AW | Second source register of the instruction in decode |
| ifid_is_branch | input | 1 | Instruction in decode is a conditional branch |
| branch_taken | input | 1 | Decode-stage branch comparison outcome |
| idex_rs | input | REG_AW | First source register of the instruction in execute |
| idex_rt | input | REG_AW | Second source register (load target) in execute |
| idex_rd | input | REG_AW | Resolved destination register of the instruction in execute |
| idex_regwr | input | 1 | Instruction in execute writes a register |
| idex_memrd | input | 1 | Instruction in execute is a load |
| exmem_rd | input | REG_AW | Destination register held in the execute/memory register |
| exmem_regwr | input | 1 | Instruction in memory writes a register |
| exmem_memrd | input | 1 | Instruction in memory is a load |
| memwb_rd | input | REG_AW | Destination register held in the memory/writeback register |
| memwb_regwr | input | 1 | Instruction in writeback writes a register |
| fwd_a | output | 2 | First ALU operand source: 0 register file, 1 exec/mem, 2 mem/wb |
| fwd_b | output | 2 | Second ALU operand source, same encoding |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| if_flush | output | 1 | Discard the instruction now being fetched |
| idex_bubble | output | 1 | Insert a no-op into the decode/execute register |

## Verification
The bypass selects are driven with register numbers drawn from a four-value range. This makes single matches, double matches and register-0 matches frequent, so priority and the zero exclusion are both separated from plain matching. Directed cases set up a load followed by a reader on either source, a load into register 0, and a non-load with the same destination. Each of these shows whether the stall depends on the load flag and the target rather than on any match. Branch cases place the producer one stage ahead and two stages ahead, and they combine a taken branch with each stall cause. Together these tell an ungated flush apart from one that correctly waits for the stall to clear.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'd0,
    SEL_EXMEM   = 2'd1,
    SEL_MEMWB   = 2'd2
  } byp_sel_e;
endpackage

// File: rtl/operand_bypass.sv
module operand_bypass
  import hzc_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  output byp_sel_e          sel
);
  logic ex_hit, wb_hit;

  assign ex_hit = ex_wr && (ex_dst != '0) && (ex_dst == src);
  assign wb_hit = wb_wr && (wb_dst != '0) && (wb_dst == src);

  always_comb begin
    if (ex_hit)      sel = SEL_EXMEM;
    else if (wb_hit) sel = SEL_MEMWB;
    else             sel = SEL_REGFILE;
  end

  always_comb begin
    p_sel_legal_r5: assert (sel != byp_sel_e'(2'd3));
    p_zero_never_bypassed_r5: assert ((src != '0) || (sel == SEL_REGFILE));
    p_newer_wins_r3: assert (!((sel == SEL_MEMWB) && ex_wr && (ex_dst == src) && (src != '0)));
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_AW = 5
) (
  input  logic              ld_in_ex,
  input  logic [REG_AW-1:0] ld_dst,
  input  logic [REG_AW-1:0] rd_src0,
  input  logic [REG_AW-1:0] rd_src1,
  output logic              hazard
);
  assign hazard = ld_in_ex && (ld_dst != '0) &&
                  ((ld_dst == rd_src0) || (ld_dst == rd_src1));

  always_comb begin
    p_no_hazard_without_load_r7: assert (ld_in_ex || !hazard);
  end
endmodule

// File: rtl/branch_dep_detect.sv
module branch_dep_detect #(
  parameter int REG_AW = 5
) (
  input  logic              is_branch,
  input  logic [REG_AW-1:0] cmp_src0,
  input  logic [REG_AW-1:0] cmp_src1,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_ld,
  input  logic [REG_AW-1:0] mem_dst,
  output logic              hazard
);
  logic ex_dep, mem_dep;

  assign ex_dep  = ex_wr && (ex_dst != '0) &&
                   ((ex_dst == cmp_src0) || (ex_dst == cmp_src1));
  assign mem_dep = mem_ld && (mem_dst != '0) &&
                   ((mem_dst == cmp_src0) || (mem_dst == cmp_src1));
  assign hazard  = is_branch && (ex_dep || mem_dep);

  always_comb begin
    p_only_branches_wait_r8: assert (is_branch || !hazard);
  end
endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
  import hzc_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ifid_rs,
  input  logic [REG_AW-1:0] ifid_rt,
  input  logic              ifid_is_branch,
  input  logic              branch_taken,
  input  logic [REG_AW-1:0] idex_rs,
  input  logic [REG_AW-1:0] idex_rt,
  input  logic [REG_AW-1:0] idex_rd,
  input  logic              idex_regwr,
  input  logic              idex_memrd,
  input  logic [REG_AW-1:0] exmem_rd,
  input  logic              exmem_regwr,
  input  logic              exmem_memrd,
  input  logic [REG_AW-1:0] memwb_rd,
  input  logic              memwb_regwr,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              if_flush,
  output logic              idex_bubble
);
  localparam int NUM_OPS = 2;

  logic [REG_AW-1:0] op_src [NUM_OPS];
  byp_sel_e          op_sel [NUM_OPS];
  logic              ld_haz, br_haz, stall;

  assign op_src[0] = idex_rs;
  assign op_src[1] = idex_rt;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    operand_bypass #(.REG_AW(REG_AW)) i_byp (
      .src    (op_src[g]),
      .ex_dst (exmem_rd),
      .ex_wr  (exmem_regwr),
      .wb_dst (memwb_rd),
      .wb_wr  (memwb_regwr),
      .sel    (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  load_use_detect #(.REG_AW(REG_AW)) i_ld (
    .ld_in_ex (idex_memrd),
    .ld_dst   (idex_rt),
    .rd_src0  (ifid_rs),
    .rd_src1  (ifid_rt),
    .hazard   (ld_haz)
  );

  branch_dep_detect #(.REG_AW(REG_AW)) i_br (
    .is_branch (ifid_is_branch),
    .cmp_src0  (ifid_rs),
    .cmp_src1  (ifid_rt),
    .ex_wr     (idex_regwr),
    .ex_dst    (idex_rd),
    .mem_ld    (exmem_memrd),
    .mem_dst   (exmem_rd),
    .hazard    (br_haz)
  );

  assign stall       = ld_haz || br_haz;
  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall;
  assign if_flush    = ifid_is_branch && branch_taken && !stall;

  always_comb begin
    p_flush_waits_r11: assert (!(if_flush && !pc_we));
    p_loaduse_holds_r6: assert (!(idex_memrd && (idex_rt != '0) &&
                                  (idex_rt == ifid_rs)) || (!pc_we && !ifid_we && idex_bubble));
    p_flush_needs_branch_r10: assert (!if_flush || (ifid_is_branch && branch_taken));
    p_enables_agree_r12: assert ((pc_we == ifid_we) && (idex_bubble != pc_we));
  end
endmodule

// File: tb/test_hazard_fwd_ctrl.sv
`timescale 1ns/1ps
module test_hazard_fwd_ctrl;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd, exmem_rd, memwb_rd;
  logic ifid_is_branch, branch_taken, idex_regwr, idex_memrd;
  logic exmem_regwr, exmem_memrd, memwb_regwr;
  logic [1:0] fwd_a, fwd_b;
  logic pc_we, ifid_we, if_flush, idex_bubble;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  hazard_fwd_ctrl #(.REG_AW(AW)) i_hazard_fwd_ctrl (.*);

  function automatic logic [1:0] m_fwd(logic [AW-1:0] s, logic [AW-1:0] ed, logic ew,
                                       logic [AW-1:0] wd, logic ww);
    if (ew && ed != 0 && ed == s) return 2'd1;
    if (ww && wd != 0 && wd == s) return 2'd2;
    return 2'd0;
  endfunction

  function automatic bit m_stall();
    bit lu, be, bm;
    lu = idex_memrd && idex_rt != 0 && (idex_rt == ifid_rs || idex_rt == ifid_rt);
    be = idex_regwr && idex_rd != 0 && (idex_rd == ifid_rs || idex_rd == ifid_rt);
    bm = exmem_memrd && exmem_rd != 0 && (exmem_rd == ifid_rs || exmem_rd == ifid_rt);
    return lu || (ifid_is_branch && (be || bm));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    {ifid_rs, ifid_rt, idex_rs, idex_rt, idex_rd, exmem_rd, memwb_rd} = '0;
    {ifid_is_branch, branch_taken, idex_regwr, idex_memrd} = '0;
    {exmem_regwr, exmem_memrd, memwb_regwr} = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic chk_all(string req);
    bit st;
    st = m_stall();
    chk(req, "fwd_a", fwd_a, m_fwd(idex_rs, exmem_rd, exmem_regwr, memwb_rd, memwb_regwr));
    chk(req, "fwd_b", fwd_b, m_fwd(idex_rt, exmem_rd, exmem_regwr, memwb_rd, memwb_regwr));
    chk(req, "pc_we", pc_we, !st);
    chk(req, "ifid_we", ifid_we, !st);
    chk(req, "idex_bubble", idex_bubble, st);
    chk(req, "if_flush", if_flush, ifid_is_branch && branch_taken && !st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    settle();
    // R12 idle state
    chk("R12", "pc_we idle", pc_we, 1);
    chk("R12", "bubble idle", idex_bubble, 0);
    chk("R12", "flush idle", if_flush, 0);
    chk("R12", "fwd_a idle", fwd_a, 0);

    // R1 exec/mem match on rs
    idle(); idex_rs = 5'd7; exmem_rd = 5'd7; exmem_regwr = 1; settle();
    chk("R1", "fwd_a", fwd_a, 1);
    // R2 mem/wb match only
    idle(); idex_rs = 5'd9; memwb_rd = 5'd9; memwb_regwr = 1; exmem_rd = 5'd9; settle();
    chk("R2", "fwd_a", fwd_a, 2);
    // R3 both match
    idle(); idex_rs = 5'd4; idex_rt = 5'd4; exmem_rd = 5'd4; exmem_regwr = 1;
    memwb_rd = 5'd4; memwb_regwr = 1; settle();
    chk("R3", "fwd_a", fwd_a, 1);
    chk("R3", "fwd_b", fwd_b, 1);
    // R4 rt path, rs different
    idle(); idex_rs = 5'd1; idex_rt = 5'd12; memwb_rd = 5'd12; memwb_regwr = 1; settle();
    chk("R4", "fwd_b", fwd_b, 2);
    chk("R4", "fwd_a", fwd_a, 0);
    // R5 register 0
    idle(); exmem_regwr = 1; memwb_regwr = 1; settle();
    chk("R5", "fwd_a r0", fwd_a, 0);
    chk("R5", "fwd_b r0", fwd_b, 0);
    // R6 load-use on rt of decode
    idle(); idex_memrd = 1; idex_regwr = 1; idex_rt = 5'd3; idex_rd = 5'd3;
    ifid_rs = 5'd8; ifid_rt = 5'd3; settle();
    chk("R6", "pc_we", pc_we, 0);
    chk("R6", "ifid_we", ifid_we, 0);
    chk("R6", "idex_bubble", idex_bubble, 1);
    // R7 load into r0
    idle(); idex_memrd = 1; ifid_rs = 5'd0; settle();
    chk("R7", "pc_we r0 load", pc_we, 1);
    // R7 non-load matching destination, no branch
    idle(); idex_regwr = 1; idex_rd = 5'd6; idex_rt = 5'd6; ifid_rs = 5'd6; settle();
    chk("R7", "pc_we alu", pc_we, 1);
    // R8 branch after ALU producer
    idle(); ifid_is_branch = 1; ifid_rs = 5'd6; idex_regwr = 1; idex_rd = 5'd6; settle();
    chk("R8", "pc_we", pc_we, 0);
    chk("R8", "bubble", idex_bubble, 1);
    // R9 branch two behind a load
    idle(); ifid_is_branch = 1; ifid_rt = 5'd11; exmem_memrd = 1; exmem_regwr = 1;
    exmem_rd = 5'd11; settle();
    chk("R9", "pc_we", pc_we, 0);
    // R9 ALU producer in memory does not stall a branch
    exmem_memrd = 0; settle();
    chk("R9", "pc_we alu in mem", pc_we, 1);
    // R10 taken branch flushes
    idle(); ifid_is_branch = 1; branch_taken = 1; ifid_rs = 5'd2; settle();
    chk("R10", "if_flush", if_flush, 1);
    // R11 taken branch stalled
    idex_regwr = 1; idex_rd = 5'd2; settle();
    chk("R11", "if_flush stalled", if_flush, 0);
    chk("R11", "pc_we stalled", pc_we, 0);
    // R11 load-use with taken branch
    idle(); ifid_is_branch = 1; branch_taken = 1; idex_memrd = 1; idex_rt = 5'd5;
    ifid_rt = 5'd5; settle();
    chk("R11", "if_flush loaduse", if_flush, 0);

    for (int i = 0; i < 3000; i++) begin
      ifid_rs = AW'($urandom_range(0, 3)); ifid_rt = AW'($urandom_range(0, 3));
      idex_rs = AW'($urandom_range(0, 3)); idex_rt = AW'($urandom_range(0, 3));
      idex_rd = AW'($urandom_range(0, 3)); exmem_rd = AW'($urandom_range(0, 3));
      memwb_rd = AW'($urandom_range(0, 3));
      ifid_is_branch = 1'($urandom_range(0, 1)); branch_taken = 1'($urandom_range(0, 1));
      idex_regwr = 1'($urandom_range(0, 1)); idex_memrd = 1'($urandom_range(0, 1));
      exmem_regwr = 1'($urandom_range(0, 1)); exmem_memrd = 1'($urandom_range(0, 1));
      memwb_regwr = 1'($urandom_range(0, 1));
      settle();
      chk_all("R1 R4 R6 R10 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule